// File: doc/BRIEF.md
# Flux Pulse Train Generator

This block rebuilds the read-data pulse stream of a floppy drive from a queue of flux intervals. Software or an upstream engine pushes 16-bit interval values into an internal ring. Once the stream is started, a counter driven by a prescaled sample tick measures out each interval. Every interval opens with an active pulse of fixed width, and the output then stays inactive until the counter reaches the interval's reload value. At that point the next value is taken from the ring.

The pulse leaves the block only while the drive is selected and the stream is running. Its active level is chosen by a parameter. A one-cycle strobe marks the start of every interval, so that an external index synchroniser can follow the stream position. If the ring runs dry, the block keeps replaying the last interval and raises a sticky underrun flag.

Top module: `flux_pulse_gen`

## Requirements
- R1: A loaded interval value N gives a period of exactly N+1 sample ticks, because the counter runs from 0 through N inclusive.
- R2: Each period begins with the output active for PULSE_TICKS sample ticks, where PULSE_TICKS is PULSE_NS times SAMPLE_MHZ divided by 1000, rounded up. The output is inactive for the rest of the period. A period shorter than the pulse stays active throughout.
- R3: One sample tick occurs every SYS_MHZ/SAMPLE_MHZ system clocks. The prescaler restarts from zero when the stream is started.
- R4: `period_strobe` is high for exactly one clock, in the first clock of every period.
- R5: The ring holds at most DEPTH-1 values, so one slot always stays empty. `ring_full` is high at that fill level, and a push while full is dropped.
- R6: A period boundary that finds the ring empty reuses the previous interval and sets `underrun`. The flag stays set until it is cleared.
- R7: `clear_underrun` clears the flag one clock later, unless an underrun occurs in the same clock, in which case the flag stays set.
- R8: When ACTIVE_LOW is 1, the active level of `flux_out` is 0 and the idle level is 1. When ACTIVE_LOW is 0, both levels are inverted.
- R9: `flux_out` shows a pulse only while `drive_sel` is high. Otherwise it holds the idle level, and the stream timing is not affected.
- R10: `stream_stop` halts the counter and returns `flux_out` to idle on the next clock. It takes priority over `stream_start`. The ring contents are kept.
- R11: `stream_start` loads the first interval and begins its pulse on the next clock. A start while the stream is already running is ignored.
- R12: `ring_empty` is high exactly when the ring holds no values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Push one interval value this clock |
| push_data | input | DATA_W | Interval value (period minus one, in sample ticks) |
| stream_start | input | 1 | Start the pulse stream |
| stream_stop | input | 1 | Stop the pulse stream |
| drive_sel | input | 1 | Output enable |
| clear_underrun | input | 1 | Clear the sticky underrun flag |
| flux_out | output | 1 | Regenerated read-data pulse |
| period_strobe | output | 1 | One-clock mark at the start of each period |
| underrun | output | 1 | Sticky: a period found the ring empty |
| ring_empty | output | 1 | Ring holds no values |
| ring_full | output | 1 | Ring holds DEPTH-1 values |

## Verification
The bench goes after the moments when the ring drains while the stream is running. A design that fetched stale ring data at that point would produce wrong period lengths. A design that cleared the period register would collapse the stream into back-to-back one-tick periods.

The bench also hits pushes into a full ring and a clear of the underrun flag on the same clock as a fresh underrun. A ring without a spare slot would overwrite unread values. A clear that won over a set would hide a real gap in the stream.

The bench measures the strobe spacing against the prescaler. An off-by-one in the counter or the tick divider shows up there as a period one tick or one clock too long. It also toggles `drive_sel` mid-stream, which exposes a design that lets select disturb the timing.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
   // Sample ticks covering a duration in ns, rounded up, at least one.
   function automatic int ns_to_ticks(input int ns, input int mhz);
      int t;
      t = (ns * mhz + 999) / 1000;
      return (t < 1) ? 1 : t;
   endfunction
endpackage

// File: rtl/fpg_tick.sv
module fpg_tick #(
   parameter int DIV = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_nodiv
         assign tick = run;
      end else begin : g_div
         localparam int W = $clog2(DIV);
         logic [W-1:0] pre;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    pre <= '0;
            else if (!run)                 pre <= '0;
            else if (pre == W'(DIV - 1))   pre <= '0;
            else                           pre <= pre + 1'b1;
         end
         assign tick = run && (pre == W'(DIV - 1));

         assert_pre_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
            pre <= W'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/fpg_ring.sv
module fpg_ring #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic              empty,
   output logic              full
);
   localparam int AW = $clog2(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     prod, cons, room;

   assign room  = cons - prod - 1'b1;
   assign full  = (room == '0);
   assign empty = (prod == cons);
   assign head  = mem[cons];

   always_ff @(posedge clk) begin
      if (push && !full) mem[prod] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod <= '0;
         cons <= '0;
      end else begin
         if (push && !full) prod <= prod + 1'b1;
         if (pop && !empty) cons <= cons + 1'b1;
      end
   end

   assert_full_drops_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |=> $stable(prod));
   assert_empty_no_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty) |=> $stable(cons));
endmodule

// File: rtl/fpg_period.sv
module fpg_period #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic              stop,
   input  logic              clr_underrun,
   input  logic              ring_empty,
   input  logic [DATA_W-1:0] ring_head,
   output logic              ring_pop,
   output logic              running,
   output logic [DATA_W-1:0] cnt,
   output logic              strobe,
   output logic              underrun
);
   logic [DATA_W-1:0] reload;
   logic wrap, load;

   assign wrap     = running && tick && (cnt == reload);
   assign load     = !stop && ((start && !running) || wrap);
   assign ring_pop = load && !ring_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running  <= 1'b0;
         cnt      <= '0;
         reload   <= '0;
         strobe   <= 1'b0;
         underrun <= 1'b0;
      end else begin
         if (stop) begin
            running <= 1'b0;
            cnt     <= '0;
         end else if (start && !running) begin
            running <= 1'b1;
            cnt     <= '0;
         end else if (running && tick) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
         end
         if (ring_pop) reload <= ring_head;
         strobe <= load;
         if (load && ring_empty) underrun <= 1'b1;
         else if (clr_underrun)  underrun <= 1'b0;
      end
   end

   assert_strobe_opens_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> (running && cnt == '0));
   assert_cnt_within_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cnt <= reload));
   assert_underrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && !clr_underrun) |=> underrun);
   assert_stop_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (!running && cnt == '0));
   assert_start_loads_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !stop && !running) |=> (running && strobe));
endmodule

// File: rtl/flux_pulse_gen.sv
module flux_pulse_gen #(
   parameter int DATA_W     = 16,
   parameter int DEPTH      = 1024,
   parameter int SYS_MHZ    = 72,
   parameter int SAMPLE_MHZ = 8,
   parameter int PULSE_NS   = 400,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_valid,
   input  logic [DATA_W-1:0] push_data,
   input  logic              stream_start,
   input  logic              stream_stop,
   input  logic              drive_sel,
   input  logic              clear_underrun,
   output logic              flux_out,
   output logic              period_strobe,
   output logic              underrun,
   output logic              ring_empty,
   output logic              ring_full
);
   import fpg_pkg::*;

   localparam int DIV         = SYS_MHZ / SAMPLE_MHZ;
   localparam int PULSE_TICKS = ns_to_ticks(PULSE_NS, SAMPLE_MHZ);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 4");
      end
      if (SAMPLE_MHZ < 1 || SYS_MHZ % SAMPLE_MHZ != 0) begin : g_bad_clk
         $error("SYS_MHZ must be a whole multiple of SAMPLE_MHZ");
      end
      if (PULSE_TICKS >= (1 << DATA_W)) begin : g_bad_pulse
         $error("pulse width does not fit the counter");
      end
   endgenerate

   logic              tick, running, pop, active;
   logic [DATA_W-1:0] head, cnt;

   fpg_tick #(.DIV(DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(running), .tick(tick)
   );

   fpg_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
      .clk(clk), .rst_n(rst_n), .push(push_valid), .push_data(push_data),
      .pop(pop), .head(head), .empty(ring_empty), .full(ring_full)
   );

   fpg_period #(.DATA_W(DATA_W)) u_period (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(stream_start),
      .stop(stream_stop), .clr_underrun(clear_underrun),
      .ring_empty(ring_empty), .ring_head(head), .ring_pop(pop),
      .running(running), .cnt(cnt), .strobe(period_strobe),
      .underrun(underrun)
   );

   assign active = running && drive_sel && (cnt < DATA_W'(PULSE_TICKS));

   generate
      if (ACTIVE_LOW) begin : g_low
         assign flux_out = ~active;
      end else begin : g_high
         assign flux_out = active;
      end
   endgenerate

   assert_idle_unselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_sel |-> (flux_out == ACTIVE_LOW));
   assert_idle_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stream_stop |=> (flux_out == ACTIVE_LOW));
endmodule

// File: tb/flux_pulse_gen_tb.sv
module flux_pulse_gen_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 8;
   localparam int DIV   = 3;   // 24 MHz / 8 MHz
   localparam int PW    = 2;   // 250 ns at 8 MHz

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_valid = 1'b0;
   logic [15:0] push_data = '0;
   logic        stream_start = 1'b0, stream_stop = 1'b0;
   logic        drive_sel = 1'b0, clear_underrun = 1'b0;
   logic        flux_out, period_strobe, underrun, ring_empty, ring_full;

   int checks = 0, errors = 0, cycles = 0;

   flux_pulse_gen #(.DATA_W(16), .DEPTH(DEPTH), .SYS_MHZ(24), .SAMPLE_MHZ(8),
                    .PULSE_NS(250), .ACTIVE_LOW(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
      .stream_start(stream_start), .stream_stop(stream_stop),
      .drive_sel(drive_sel), .clear_underrun(clear_underrun),
      .flux_out(flux_out), .period_strobe(period_strobe), .underrun(underrun),
      .ring_empty(ring_empty), .ring_full(ring_full)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // Behavioural reference model
   int q[$];
   int m_run = 0, m_cnt = 0, m_pre = 0, m_rel = 0, m_und = 0, m_strb = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_run = 0; m_cnt = 0; m_pre = 0; m_rel = 0; m_und = 0; m_strb = 0;
      end else begin
         int sz0;
         bit fetch, und_set;
         sz0 = q.size();
         fetch = 0; und_set = 0; m_strb = 0;
         if (stream_stop) begin
            m_run = 0; m_cnt = 0; m_pre = 0;
         end else if (stream_start && !m_run) begin
            m_run = 1; m_cnt = 0; m_pre = 0; fetch = 1;
         end else if (m_run) begin
            if (m_pre == DIV - 1) begin
               m_pre = 0;
               if (m_cnt == m_rel) begin m_cnt = 0; fetch = 1; end
               else m_cnt++;
            end else m_pre++;
         end
         if (fetch) begin
            m_strb = 1;
            if (sz0 > 0) m_rel = q.pop_front();
            else begin m_und = 1; und_set = 1; end
         end
         if (clear_underrun && !und_set) m_und = 0;
         if (push_valid && sz0 < DEPTH - 1) q.push_back(int'(push_data));
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         int act_lvl;
         act_lvl = (m_run && drive_sel && m_cnt < PW) ? 0 : 1;
         chk("R1 R2 R8 R9 flux_out", int'(flux_out), act_lvl);
         chk("R4 R11 period_strobe", int'(period_strobe), m_strb);
         chk("R6 R7 underrun", int'(underrun), m_und);
         chk("R12 ring_empty", int'(ring_empty), int'(q.size() == 0));
         chk("R5 ring_full", int'(ring_full), int'(q.size() == DEPTH - 1));
      end
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic push(input int v);
      push_valid = 1'b1; push_data = 16'(v);
      step();
      push_valid = 1'b0;
   endtask

   initial begin
      int n;
      repeat (3) step();
      // reset state
      chk("R12 reset empty", int'(ring_empty), 1);
      chk("R5 reset full", int'(ring_full), 0);
      chk("R6 reset underrun", int'(underrun), 0);
      chk("R8 reset idle level", int'(flux_out), 1);
      rst_n = 1'b1;
      step();
      push(5); push(8); push(3); push(6);
      drive_sel = 1'b1;
      stream_start = 1'b1;
      step();
      stream_start = 1'b0;
      // R3 R1: first period of 6 ticks at 3 clocks per tick
      n = 0;
      do begin @(negedge clk); n++; end while (!period_strobe);
      chk("R1 R3 strobe spacing", n, 18);
      #1;
      // R11: start while running is ignored
      stream_start = 1'b1; step(); stream_start = 1'b0;
      // R9: deselect mid-stream
      repeat (10) step();
      drive_sel = 1'b0;
      repeat (20) step();
      drive_sel = 1'b1;
      // let ring drain into underrun (R6)
      repeat (120) step();
      chk("R6 underrun after drain", int'(underrun), 1);
      clear_underrun = 1'b1; step(); clear_underrun = 1'b0;
      // R7: clear during continuous underrun may race a new underrun; model decides
      push(2); push(9);
      repeat (80) step();
      clear_underrun = 1'b1;
      repeat (2) step();
      clear_underrun = 1'b0;
      // R10 stop
      stream_stop = 1'b1; stream_start = 1'b1; step();
      stream_stop = 1'b0; stream_start = 1'b0;
      repeat (5) begin
         chk("R10 idle after stop", int'(flux_out), 1);
         step();
      end
      // R5 fill past capacity while stopped
      for (int i = 0; i < DEPTH + 2; i++) push(i + 1);
      chk("R5 full at DEPTH-1", int'(ring_full), 1);
      chk("R12 not empty when full", int'(ring_empty), 0);
      clear_underrun = 1'b1; step(); clear_underrun = 1'b0;
      chk("R7 cleared", int'(underrun), 0);
      stream_start = 1'b1; step(); stream_start = 1'b0;
      repeat (300) step();
      chk("R6 underrun after full drain", int'(underrun), 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule